// File: doc/BRIEF.md
# Selectable-Input Register with All-Zeros Flag

This block is a register of configurable width built from identical one-bit slices. Each slice holds a two-way selector ahead of a D flip-flop. One select line is shared by all slices. On every rising clock edge the register loads either the whole first data word or the whole second data word. The register has no load enable, so it captures on every edge. The stored word appears on the data output.

A flag output reports whether every stored bit is zero. The flag is decoded from the flip-flop outputs and not from the selector outputs. It therefore describes the word already held and changes only after a clock edge has updated that word. A synchronous active-high reset clears the whole register, which makes the flag read high once the reset edge has passed. The block can sit in a datapath wherever one of two sources must be registered and a zero-result indication is wanted.

Top module: `selreg_zflag`

## Requirements
- R1: The register width is the parameter WIDTH, which defaults to 8. Both data inputs and the data output are WIDTH bits wide.
- R2: When `sel` is 0 at a rising clock edge and reset is low, `word_q` takes the value of `x_in` sampled at that edge.
- R3: When `sel` is 1 at a rising clock edge and reset is low, `word_q` takes the value of `y_in` sampled at that edge.
- R4: The word that is not selected has no effect. With `sel` at 0, changes on `y_in` leave `word_q` unchanged. With `sel` at 1, changes on `x_in` leave `word_q` unchanged.
- R5: One select line drives all bit positions. Every bit of a captured word comes from the same source, including patterns where the two sources differ in every bit.
- R6: `zero_flag` is 1 exactly when all WIDTH bits of `word_q` are 0. A single 1 in any bit position, including the lowest or the highest, holds it at 0.
- R7: `zero_flag` depends only on the stored word. Input changes between edges do not alter it, and it updates in the same cycle as `word_q`, one edge after the selected data changes.
- R8: When `rst` is 1 at a rising edge, every stored bit becomes 0 and `zero_flag` reads 1 after that edge. Raising `rst` between edges leaves `word_q` unchanged until the next edge.
- R9: Between rising edges `word_q` stays stable whatever `sel`, `x_in` and `y_in` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; capture happens on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the register |
| sel | input | 1 | Shared source select: 0 picks `x_in`, 1 picks `y_in` |
| x_in | input | WIDTH | First candidate word |
| y_in | input | WIDTH | Second candidate word |
| word_q | output | WIDTH | Stored word |
| zero_flag | output | 1 | High when every stored bit is 0 |

## Verification
A slice whose selector were wired the wrong way, or tied to the wrong source, would show the wrong bit on `word_q` at the first edge after the two sources differ in that position. The bench therefore drives complementary words on the two inputs. A fault in the zero decode, for example a group of bits missing from the reduction, would show on `zero_flag` only when a lone 1 sits in that group, so walking-one patterns are applied across every bit. A flag decoded from the selector instead of the register would change before the edge, and the bench catches this by changing inputs between edges and sampling before the next edge.

// File: rtl/selreg_pkg.sv
package selreg_pkg;

  // Encoding of the shared select line.
  typedef enum logic {
    SRC_X = 1'b0,
    SRC_Y = 1'b1
  } src_sel_e;

  // One-bit two-way selection used by every slice.
  function automatic logic pick_bit(input src_sel_e s, input logic a, input logic b);
    logic r;
    case (s)
      SRC_X:   r = a;
      default: r = b;
    endcase
    return r;
  endfunction

  // Number of groups needed to cover a width with lanes of a given size.
  function automatic int group_count(input int width, input int lane);
    return (width + lane - 1) / lane;
  endfunction

endpackage

// File: rtl/selreg_slice.sv
module selreg_slice
  import selreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_sel_e sel,
  input  logic     a_bit,
  input  logic     b_bit,
  output logic     d_next,
  output logic     q_bit
);

  // Selector output, brought out as a named wire.
  assign d_next = pick_bit(sel, a_bit, b_bit);

  always_ff @(posedge clk) begin
    if (rst) q_bit <= 1'b0;
    else     q_bit <= d_next;
  end

endmodule

// File: rtl/selreg_zero_detect.sv
module selreg_zero_detect
  import selreg_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LANE  = 4
) (
  input  logic [WIDTH-1:0] vec,
  output logic             all_zero
);

  localparam int GROUPS = group_count(WIDTH, LANE);
  localparam int PADDED = GROUPS * LANE;

  logic [PADDED-1:0] vec_pad;
  logic [GROUPS-1:0] grp_any;

  assign vec_pad = {{(PADDED-WIDTH){1'b0}}, vec};

  // First level: one OR per lane of bits.
  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    assign grp_any[g] = |vec_pad[g*LANE +: LANE];
  end

  // Second level: combine the lane results.
  assign all_zero = ~(|grp_any);

endmodule

// File: rtl/selreg_zflag.sv
module selreg_zflag
  import selreg_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LANE  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  output logic [WIDTH-1:0] word_q,
  output logic             zero_flag
);

  src_sel_e         sel_e;
  logic [WIDTH-1:0] next_word;

  assign sel_e = src_sel_e'(sel);

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    selreg_slice u_slice (
      .clk    (clk),
      .rst    (rst),
      .sel    (sel_e),
      .a_bit  (x_in[i]),
      .b_bit  (y_in[i]),
      .d_next (next_word[i]),
      .q_bit  (word_q[i])
    );
  end

  selreg_zero_detect #(
    .WIDTH (WIDTH),
    .LANE  (LANE)
  ) u_zero (
    .vec      (word_q),
    .all_zero (zero_flag)
  );

  // R8: a reset edge clears the stored word.
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (word_q == '0));

  // R2: first source captured when select is low.
  p_capture_x_r2: assert property (@(posedge clk) disable iff (rst)
    (sel == 1'b0) |=> (word_q == $past(x_in)));

  // R3: second source captured when select is high.
  p_capture_y_r3: assert property (@(posedge clk) disable iff (rst)
    (sel == 1'b1) |=> (word_q == $past(y_in)));

  // R6: flag set implies an empty register.
  p_flag_means_zero_r6: assert property (@(posedge clk) disable iff (rst)
    zero_flag |-> (word_q == '0));

  // R6: an empty register raises the flag.
  p_zero_means_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (word_q == '0) |-> zero_flag);

  // R7: a zero word on the chosen source sets the flag one edge later.
  p_flag_lag_r7: assert property (@(posedge clk) disable iff (rst)
    (next_word == '0) |=> zero_flag);

endmodule

// File: tb/sim_selreg_zflag.sv
module sim_selreg_zflag;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel = 1'b0;
  logic [W-1:0] x_in = '0;
  logic [W-1:0] y_in = '0;
  logic [W-1:0] word_q;
  logic         zero_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  selreg_zflag #(.WIDTH(W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .x_in      (x_in),
    .y_in      (y_in),
    .word_q    (word_q),
    .zero_flag (zero_flag)
  );

  // Advance past the next rising edge, to a point away from it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic exp_flag(input logic [W-1:0] v);
    return (v == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic load(input logic s, input logic [W-1:0] x, input logic [W-1:0] y);
    sel = s; x_in = x; y_in = y;
    tick();
  endtask

  task automatic t_reset();
    x_in = 8'hA5; y_in = 8'h5A; sel = 1'b1;
    tick(); tick();
    check("R8 reset word", word_q, '0);
    check("R8 reset flag", {7'b0, zero_flag}, 8'h01);
    rst = 1'b0;
    check("R1 width", $bits(word_q), 8);
  endtask

  task automatic t_select_x();
    load(1'b0, 8'h3C, 8'hC3);
    check("R2 pick x", word_q, 8'h3C);
    check("R6 flag low", {7'b0, zero_flag}, 8'h00);
  endtask

  task automatic t_select_y();
    load(1'b1, 8'h3C, 8'hC3);
    check("R3 pick y", word_q, 8'hC3);
  endtask

  task automatic t_complement();
    load(1'b0, 8'hFF, 8'h00);
    check("R5 all from x", word_q, 8'hFF);
    load(1'b1, 8'hFF, 8'h00);
    check("R5 all from y", word_q, 8'h00);
    check("R5 flag", {7'b0, zero_flag}, 8'h01);
    load(1'b1, 8'h55, 8'hAA);
    check("R5 alt y", word_q, 8'hAA);
  endtask

  task automatic t_ignore_other();
    load(1'b0, 8'h12, 8'h00);
    y_in = 8'hEE; tick();
    check("R4 y ignored", word_q, 8'h12);
    load(1'b1, 8'h00, 8'h34);
    x_in = 8'h77; tick();
    check("R4 x ignored", word_q, 8'h34);
  endtask

  task automatic t_walk();
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] v;
      v = '0;
      v[i] = 1'b1;
      load(i[0], v, v);
      check("R6 walk word", word_q, v);
      check("R6 walk flag", {7'b0, zero_flag}, {7'b0, exp_flag(v)});
    end
  endtask

  task automatic t_flag_lag();
    load(1'b0, 8'h80, 8'h00);
    // Select a zero source but stay before the edge.
    sel = 1'b1;
    #1;
    check("R7 flag before edge", {7'b0, zero_flag}, 8'h00);
    check("R9 word before edge", word_q, 8'h80);
    tick();
    check("R7 flag after edge", {7'b0, zero_flag}, 8'h01);
    x_in = 8'h01; y_in = 8'h02; sel = 1'b0;
    #1;
    check("R9 stable zero", word_q, 8'h00);
    check("R7 flag stable", {7'b0, zero_flag}, 8'h01);
    tick();
    check("R7 flag falls", {7'b0, zero_flag}, 8'h00);
  endtask

  task automatic t_sync_reset();
    load(1'b0, 8'h69, 8'h00);
    rst = 1'b1;
    #1;
    check("R8 sync hold", word_q, 8'h69);
    tick();
    check("R8 sync clear", word_q, 8'h00);
    check("R8 sync flag", {7'b0, zero_flag}, 8'h01);
    rst = 1'b0;
    load(1'b1, 8'h00, 8'h0F);
    check("R8 resume", word_q, 8'h0F);
  endtask

  initial begin
    t_reset();
    t_select_x();
    t_select_y();
    t_complement();
    t_ignore_other();
    t_walk();
    t_flag_lag();
    t_sync_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule